// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block times the clock line of an I2C master. A divided tick, taken from the reference clock by a power-of-two prescaler, paces two phase counters. The low phase drives SCL low. The high phase leaves SCL released, and it begins counting only once the returning line has been seen high through a synchroniser and a glitch filter. A slave that holds SCL low therefore stretches the period without any extra logic. Each phase lasts its programmed count plus a fixed overhead that stands for the sampling path: four prescaled ticks when the prescaler is bypassed, and three otherwise.

The prescale code and both phase counts are captured only while the protocol soft reset is held. The generator restarts with a new low phase when that reset is released. The byte engine runs off two single-cycle ticks, one at the start of each low phase and one at the start of each high phase. While the block is disabled or held in soft reset, SCL stays released.

Top module: `scl_rate_gen`

## Requirements
- R1: After the asynchronous reset, scl_drive_low, low_start and high_start are all 0.
- R2: While gen_en is 0 or soft_rst is 1, scl_drive_low stays 0 and neither tick pulses, from the first clock edge on.
- R3: With soft_rst low, the clock edge that first samples gen_en high starts a low phase, so low_start and scl_drive_low are 1 in the cycle after that edge.
- R4: A low phase keeps scl_drive_low at 1 for exactly (L + K) * 2^P reference clocks. P is the prescale code (0 to 7). L is cfg_low[4:0]. K is 4 when P is 0 and 3 otherwise.
- R5: The time from high_start to the next low_start is exactly (H + K) * 2^P reference clocks, where H is cfg_high[4:0].
- R6: A count field of 0 acts as 1. Bits 7:5 of cfg_low and cfg_high have no effect.
- R7: When SCL is free, high_start pulses 5 clocks after scl_drive_low falls. A slave that holds scl_in low delays high_start by the length of the hold, so high counting starts only after SCL is seen high.
- R8: A high pulse of one clock on scl_in while the line is otherwise held low does not start the high phase.
- R9: The configuration inputs are captured only while soft_rst is 1. Changes made while soft_rst is 0 do not alter phase lengths until the next soft reset.
- R10: low_start and high_start are never 1 together, and neither is 1 on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Protocol soft reset; configuration loads while high |
| gen_en | input | 1 | Generator enable |
| cfg_prescale | input | 3 | Power-of-two prescale code |
| cfg_low | input | 8 | Low-phase count in bits 4:0 |
| cfg_high | input | 8 | High-phase count in bits 4:0 |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| low_start | output | 1 | One-cycle tick at the start of a low phase |
| high_start | output | 1 | One-cycle tick at the start of a high phase |

## Verification
Every output is a flop, and the checks sample it at the falling clock edge. low_start is due one cycle after gen_en or a soft-reset release is sampled, and on a free line high_start is due five cycles after SCL is released. The phase lengths are timed in reference-clock counts between these ticks and the fall of scl_drive_low, and they must equal the arithmetic formula exactly, with no tolerance. Slave stretch and glitch cases hold the line at precise counts after release, so the expected delay is the hold length plus five.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 5;
  localparam int REG_W  = 8;
  localparam int PH_W   = CNT_W + 1;
  localparam int PRE_W  = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Prescaled ticks per phase: clamped count plus sampling overhead.
  function automatic logic [PH_W-1:0] phase_ticks(input logic [CNT_W-1:0] cnt,
                                                  input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] base;
    base = (cnt == '0) ? CNT_W'(1) : cnt;
    return PH_W'(base) + ((code == '0) ? PH_W'(4) : PH_W'(3));
  endfunction

  // Low bits of the prescale counter that must all be set for a tick.
  function automatic logic [PRE_W-1:0] prescale_mask(input logic [CODE_W-1:0] code);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << code;
    return PRE_W'(one_hot - 1'b1);
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              pre_tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;

  assign mask     = prescale_mask(code);
  assign pre_tick = ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else          div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_filt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   sampled;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic d;
    if (g == 0) begin : g_first
      assign d = scl_in;
    end else begin : g_next
      assign d = sync_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b1;
      else        sync_q[g] <= d;
    end
  end

  assign sampled = sync_q[SYNC_STAGES-1];

  // Accept a new level only once two consecutive samples agree.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      scl_filt <= 1'b1;
    end else begin
      prev_q <= sampled;
      if (sampled == prev_q) scl_filt <= sampled;
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            pre_tick,
  input  logic            scl_filt,
  input  logic [PH_W-1:0] low_len,
  input  logic [PH_W-1:0] high_len,
  output logic            scl_drive_low,
  output logic            low_start,
  output logic            high_start,
  output logic            phase_clr
);
  phase_e          state_q, state_d;
  logic [PH_W-1:0] cnt_q;
  logic            go_low, go_high;
  logic            low_done, high_done;

  assign low_done  = pre_tick && (cnt_q == PH_W'(low_len - 1'b1));
  assign high_done = pre_tick && (cnt_q == PH_W'(high_len - 1'b1));

  always_comb begin
    state_d = state_q;
    go_low  = 1'b0;
    go_high = 1'b0;
    if (!active) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE: begin state_d = PH_LOW; go_low = 1'b1; end
        PH_LOW:  if (low_done) state_d = PH_WAIT;
        PH_WAIT: if (scl_filt) begin state_d = PH_HIGH; go_high = 1'b1; end
        PH_HIGH: if (high_done) begin state_d = PH_LOW; go_low = 1'b1; end
        default: state_d = PH_IDLE;
      endcase
    end
  end

  assign phase_clr     = (state_d != state_q) || (state_q == PH_IDLE) || (state_q == PH_WAIT);
  assign scl_drive_low = (state_q == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      cnt_q      <= '0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else begin
      state_q    <= state_d;
      low_start  <= go_low;
      high_start <= go_high;
      if (state_d != state_q) cnt_q <= '0;
      else if (pre_tick)      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              gen_en,
  input  logic [CODE_W-1:0] cfg_prescale,
  input  logic [REG_W-1:0]  cfg_low,
  input  logic [REG_W-1:0]  cfg_high,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              low_start,
  output logic              high_start
);
  logic [CODE_W-1:0] sh_code;
  logic [CNT_W-1:0]  sh_low, sh_high;
  logic [PH_W-1:0]   low_len, high_len;
  logic              active, pre_tick, phase_clr, scl_filt;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_low[REG_W-1:CNT_W], cfg_high[REG_W-1:CNT_W]};

  // Shadow configuration: loads only while the protocol reset is held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_code <= '0;
      sh_low  <= CNT_W'(1);
      sh_high <= CNT_W'(1);
    end else if (soft_rst) begin
      sh_code <= cfg_prescale;
      sh_low  <= cfg_low[CNT_W-1:0];
      sh_high <= cfg_high[CNT_W-1:0];
    end
  end

  assign active   = gen_en && !soft_rst;
  assign low_len  = phase_ticks(sh_low, sh_code);
  assign high_len = phase_ticks(sh_high, sh_code);

  scl_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(phase_clr), .code(sh_code), .pre_tick(pre_tick)
  );

  scl_in_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .scl_filt(scl_filt)
  );

  scl_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active), .pre_tick(pre_tick),
    .scl_filt(scl_filt), .low_len(low_len), .high_len(high_len),
    .scl_drive_low(scl_drive_low), .low_start(low_start),
    .high_start(high_start), .phase_clr(phase_clr)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
  import scl_gen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              gen_en,
  input logic              scl_drive_low,
  input logic              low_start,
  input logic              high_start,
  input logic              scl_filt,
  input logic [CODE_W-1:0] sh_code,
  input logic [CNT_W-1:0]  sh_low,
  input logic [CNT_W-1:0]  sh_high
);
  p_idle_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || !gen_en) |=> (!scl_drive_low && !low_start && !high_start));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |-> scl_drive_low);

  p_high_on_filtered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> ($past(scl_filt) && !scl_drive_low));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && $past(!soft_rst)) |-> ($stable(sh_code) && $stable(sh_low) && $stable(sh_high)));

  p_tick_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_start && high_start));

  p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (low_start || high_start) |=> (!low_start && !high_start));
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .gen_en(gen_en),
  .scl_drive_low(scl_drive_low), .low_start(low_start), .high_start(high_start),
  .scl_filt(scl_filt), .sh_code(sh_code), .sh_low(sh_low), .sh_high(sh_high)
);

// File: tb/test_scl_rate_gen.sv
`timescale 1ns/1ps
module test_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       gen_en = 1'b0;
  logic [2:0] cfg_prescale = '0;
  logic [7:0] cfg_low = '0;
  logic [7:0] cfg_high = '0;
  logic       hold_low = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, low_start, high_start;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int tick_bad = 0;
  logic prev_tick = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_in = !scl_drive_low && !hold_low;

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .gen_en(gen_en),
    .cfg_prescale(cfg_prescale), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .low_start(low_start), .high_start(high_start)
  );

  // R10 monitor: ticks exclusive and single-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (low_start && high_start) tick_bad++;
      if (prev_tick && (low_start || high_start)) tick_bad++;
      prev_tick = low_start || high_start;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_len(input int field, input int code);
    int base;
    base = field % 32;
    if (base < 1) base = 1;
    if (code == 0) base = base + 4;
    else           base = base + 3;
    return base * (2 ** code);
  endfunction

  task automatic configure(input int code, input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    soft_rst = 1'b1;
    cfg_prescale = 3'(code);
    cfg_low = lo;
    cfg_high = hi;
    repeat (2) @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic measure(input int stretch, input bit glitch,
                         output int lo, output int wt, output int hi);
    int t0, t1, t2, t3;
    do @(negedge clk); while (!low_start);
    t0 = cyc;
    if (stretch > 0) hold_low = 1'b1;
    do @(negedge clk); while (scl_drive_low);
    t1 = cyc;
    if (stretch > 0) begin
      for (int k = 0; k < stretch; k++) begin
        if (glitch && k == 2) hold_low = 1'b0;
        else                  hold_low = 1'b1;
        @(negedge clk);
      end
      hold_low = 1'b0;
    end
    while (!high_start) @(negedge clk);
    t2 = cyc;
    do @(negedge clk); while (!low_start);
    t3 = cyc;
    lo = t1 - t0;
    wt = t2 - t1;
    hi = t3 - t2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int lo, wt, hi, cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 drive", int'(scl_drive_low), 0);
    check_eq("R1 ticks", int'(low_start) + int'(high_start), 0);
    rst_n = 1'b1;

    // R2: disabled stays released
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt += int'(scl_drive_low) + int'(low_start) + int'(high_start);
    end
    check_eq("R2 disabled", cnt, 0);

    // R3: enable starts a fresh low phase next cycle
    configure(0, 8'd5, 8'd7);
    @(negedge clk);
    gen_en = 1'b1;
    @(negedge clk);
    check_eq("R3 low_start", int'(low_start), 1);
    check_eq("R3 drive", int'(scl_drive_low), 1);
    measure(0, 1'b0, lo, wt, hi);
    check_eq("R4 low", lo, expect_len(5, 0));
    check_eq("R5 high", hi, expect_len(7, 0));
    check_eq("R7 free wait", wt, 5);

    // Sweep code 0 over all low counts, upper bits nonzero (R6)
    for (int l = 0; l < 32; l++) begin
      configure(0, {3'(l + 3), 5'(l)}, {3'(7 - (l % 8)), 5'(31 - l)});
      measure(0, 1'b0, lo, wt, hi);
      check_eq((l == 0) ? "R6 low zero" : "R4 low", lo, expect_len(l, 0));
      check_eq((l == 31) ? "R6 high zero" : "R5 high", hi, expect_len(31 - l, 0));
      check_eq("R7 wait", wt, 5);
    end

    // Other prescale codes
    for (int c = 1; c < 8; c++) begin
      configure(c, 8'hE0, 8'h1F);
      measure(0, 1'b0, lo, wt, hi);
      check_eq("R6 low zero prescaled", lo, expect_len(0, c));
      check_eq("R5 high prescaled", hi, expect_len(31, c));
      configure(c, 8'h5F, 8'hA3);
      measure(0, 1'b0, lo, wt, hi);
      check_eq("R4 low prescaled", lo, expect_len(31, c));
      check_eq("R5 high prescaled", hi, expect_len(3, c));
    end

    // R7: slave stretch; R8: one-cycle glitch rejected
    configure(1, 8'd4, 8'd4);
    measure(12, 1'b0, lo, wt, hi);
    check_eq("R7 stretch wait", wt, 17);
    check_eq("R7 high after stretch", hi, expect_len(4, 1));
    measure(12, 1'b1, lo, wt, hi);
    check_eq("R8 glitch wait", wt, 17);

    // R9: config changes without soft reset have no effect
    configure(0, 8'd6, 8'd9);
    @(negedge clk);
    cfg_low = 8'd20;
    cfg_high = 8'd2;
    cfg_prescale = 3'd2;
    measure(0, 1'b0, lo, wt, hi);
    check_eq("R9 low frozen", lo, expect_len(6, 0));
    check_eq("R9 high frozen", hi, expect_len(9, 0));
    configure(2, 8'd20, 8'd2);
    measure(0, 1'b0, lo, wt, hi);
    check_eq("R9 low reloaded", lo, expect_len(20, 2));

    // R2: disable mid-run, then R3 re-enable
    @(negedge clk);
    gen_en = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      cnt += int'(scl_drive_low) + int'(low_start) + int'(high_start);
      @(negedge clk);
    end
    check_eq("R2 disabled mid-run", cnt, 0);
    gen_en = 1'b1;
    @(negedge clk);
    check_eq("R3 re-enable", int'(low_start) + int'(scl_drive_low), 2);

    // R2: soft reset holds SCL released
    soft_rst = 1'b1;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      cnt += int'(scl_drive_low) + int'(low_start) + int'(high_start);
      @(negedge clk);
    end
    soft_rst = 1'b0;
    check_eq("R2 soft reset", cnt, 0);

    check_eq("R10 tick shape", tick_bad, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule